// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries short command words between two ports that run on unrelated clocks, beside a data queue rather than through it. Port A writes into the first mail register, which port B reads. Port B writes into the second mail register, which port A reads. Each register has an active-low full flag on the writer's side. The flag goes low when a write is accepted. It returns high once the far side has read the word. A write that arrives while the flag is low is dropped.

Each port has a mailbox-select input. When it is high, the port's access and its output data use the mail register. When it is low, the output shows the queue data that the surrounding logic supplies. The configured port B bus width (36, 18 or 9 bits) limits which lanes carry mail in both directions. The lanes above that width are stored and presented as zero. Each flag crosses domains through a toggle handshake with two-flop synchronizers.

Top module: `dual_clock_mailbox`

## Requirements
- R1: While `rst` is high and afterwards until the first accepted write, both full flags are high and both mail registers read as zero.
- R2: A port A access with `a_en`, `a_wr` and `a_mbx` high, on a rising `clk_a` edge while `a_full_n` is high, loads the first mail register, and `a_full_n` is low right after that edge.
- R3: A port B access with `b_en`, `b_wr` and `b_mbx` high, on a rising `clk_b` edge while `b_full_n` is high, loads the second mail register, and `b_full_n` is low right after that edge.
- R4: A write to a mail register while its full flag is low is ignored, and the register keeps its earlier contents.
- R5: `a_full_n` stays low until port B performs a mailbox read (`b_en` high, `b_wr` low, `b_mbx` high) of the pending word. It is high again at most six `clk_a` cycles after that read.
- R6: `b_full_n` stays low until port A performs a mailbox read of the pending word. It is high again at most six `clk_b` cycles after that read.
- R7: A mail register keeps its contents after it is read and changes only when a new write is accepted.
- R8: `b_size` sets the lane width for both registers: 2'b00 and 2'b11 mean 36 bits, 2'b01 means lanes 0..17, and 2'b10 means lanes 0..8. Lanes above the width are stored as zero, whatever the input holds.
- R9: Each data output is registered, with one clock of latency. It is zero when the port's output enable is low. It shows the mail register the port reads when the port's mailbox select is high, and the port's queue data input when that select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx | input | 1 | Port A mailbox select |
| a_oe | input | 1 | Port A output enable |
| a_din | input | DW | Port A write data |
| a_fifo_q | input | DW | Queue data to present on port A |
| a_dout | output | DW | Port A registered output data |
| a_full_n | output | 1 | First mail register full flag, low = full |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx | input | 1 | Port B mailbox select |
| b_oe | input | 1 | Port B output enable |
| b_size | input | 2 | Port B bus width code |
| b_din | input | DW | Port B write data |
| b_fifo_q | input | DW | Queue data to present on port B |
| b_dout | output | DW | Port B registered output data |
| b_full_n | output | 1 | Second mail register full flag, low = full |

## Verification
The assertions assume that `b_size` changes only while no mailbox write is in progress. They assume that `rst` is held for several cycles of both clocks. They also assume that a reader only relies on mail data once enough of its own clocks have passed after the write for the request toggle to arrive. The bench changes the bus width only while both flags are high. It holds reset for ten `clk_a` cycles, and it waits six reader cycles after every write before it samples mail data or issues a read. Both data flows, the dropped write, and the three widths are each tested with patterns that set bits above the width.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    BUS_FULL   = 2'b00,
    BUS_HALF   = 2'b01,
    BUS_BYTE   = 2'b10,
    BUS_FULL_X = 2'b11
  } bus_size_e;
endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dcm_channel.sv
module dcm_channel #(
  parameter int DW          = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_w,
  input  logic          clk_r,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] lane_mask,
  input  logic          rd_en,
  output logic [DW-1:0] data_q,
  output logic          full_n
);
  logic req, ack, ack_w, req_r, pending;

  // writer domain: store word and flip request
  always_ff @(posedge clk_w) begin
    if (rst) begin
      req    <= 1'b0;
      data_q <= '0;
    end else if (wr_en && full_n) begin
      data_q <= wr_data & lane_mask;
      req    <= ~req;
    end
  end

  dcm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_w), .rst(rst), .d(ack), .q(ack_w)
  );

  assign full_n = (req == ack_w);

  // reader domain: acknowledge a pending word on read
  dcm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_r), .rst(rst), .d(req), .q(req_r)
  );

  assign pending = req_r ^ ack;

  always_ff @(posedge clk_r) begin
    if (rst)                  ack <= 1'b0;
    else if (rd_en && pending) ack <= ~ack;
  end
endmodule

// File: rtl/dcm_outmux.sv
module dcm_outmux #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oe,
  input  logic          mbx,
  input  logic [DW-1:0] fifo_q,
  input  logic [DW-1:0] mail_q,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst || !oe) dout <= '0;
    else if (mbx)   dout <= mail_q;
    else            dout <= fifo_q;
  end
endmodule

// File: rtl/dual_clock_mailbox.sv
module dual_clock_mailbox #(
  parameter int DW          = 36,
  parameter int HALF_W      = 18,
  parameter int BYTE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst,
  input  logic          a_en,
  input  logic          a_wr,
  input  logic          a_mbx,
  input  logic          a_oe,
  input  logic [DW-1:0] a_din,
  input  logic [DW-1:0] a_fifo_q,
  output logic [DW-1:0] a_dout,
  output logic          a_full_n,
  input  logic          b_en,
  input  logic          b_wr,
  input  logic          b_mbx,
  input  logic          b_oe,
  input  logic [1:0]    b_size,
  input  logic [DW-1:0] b_din,
  input  logic [DW-1:0] b_fifo_q,
  output logic [DW-1:0] b_dout,
  output logic          b_full_n
);
  import dcm_pkg::*;

  localparam logic [DW-1:0] MASK_FULL = '1;
  localparam logic [DW-1:0] MASK_HALF = MASK_FULL >> (DW - HALF_W);
  localparam logic [DW-1:0] MASK_BYTE = MASK_FULL >> (DW - BYTE_W);

  logic [DW-1:0] lane_mask;
  logic [DW-1:0] mail1_q, mail2_q;

  always_comb begin
    case (bus_size_e'(b_size))
      BUS_HALF: lane_mask = MASK_HALF;
      BUS_BYTE: lane_mask = MASK_BYTE;
      default:  lane_mask = MASK_FULL;
    endcase
  end

  // A -> B register
  dcm_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
    .clk_w(clk_a), .clk_r(clk_b), .rst(rst),
    .wr_en(a_en && a_wr && a_mbx), .wr_data(a_din), .lane_mask(lane_mask),
    .rd_en(b_en && !b_wr && b_mbx),
    .data_q(mail1_q), .full_n(a_full_n)
  );

  // B -> A register
  dcm_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
    .clk_w(clk_b), .clk_r(clk_a), .rst(rst),
    .wr_en(b_en && b_wr && b_mbx), .wr_data(b_din), .lane_mask(lane_mask),
    .rd_en(a_en && !a_wr && a_mbx),
    .data_q(mail2_q), .full_n(b_full_n)
  );

  dcm_outmux #(.DW(DW)) u_out_a (
    .clk(clk_a), .rst(rst), .oe(a_oe), .mbx(a_mbx),
    .fifo_q(a_fifo_q), .mail_q(mail2_q), .dout(a_dout)
  );

  dcm_outmux #(.DW(DW)) u_out_b (
    .clk(clk_b), .rst(rst), .oe(b_oe), .mbx(b_mbx),
    .fifo_q(b_fifo_q), .mail_q(mail1_q), .dout(b_dout)
  );
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
  parameter int DW     = 36,
  parameter int BYTE_W = 9
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst,
  input logic          a_en,
  input logic          a_wr,
  input logic          a_mbx,
  input logic          b_en,
  input logic          b_wr,
  input logic          b_mbx,
  input logic          b_oe,
  input logic [1:0]    b_size,
  input logic          a_full_n,
  input logic          b_full_n,
  input logic [DW-1:0] b_dout,
  input logic [DW-1:0] mail1_q,
  input logic [DW-1:0] mail2_q
);
  AST_A_WRITE_FULL: assert property (@(posedge clk_a) disable iff (rst)
    (a_en && a_wr && a_mbx && a_full_n) |=> !a_full_n); // R2
  AST_B_WRITE_FULL: assert property (@(posedge clk_b) disable iff (rst)
    (b_en && b_wr && b_mbx && b_full_n) |=> !b_full_n); // R3
  AST_MAIL1_HELD: assert property (@(posedge clk_a) disable iff (rst)
    !a_full_n |=> $stable(mail1_q)); // R4
  AST_MAIL2_HELD: assert property (@(posedge clk_b) disable iff (rst)
    !b_full_n |=> $stable(mail2_q)); // R4
  AST_BYTE_LANES: assert property (@(posedge clk_a) disable iff (rst)
    (a_en && a_wr && a_mbx && a_full_n && b_size == 2'b10)
      |=> (mail1_q[DW-1:BYTE_W] == '0)); // R8
  AST_B_OUT_OFF: assert property (@(posedge clk_b) disable iff (rst)
    !b_oe |=> (b_dout == '0)); // R9
endmodule

bind dual_clock_mailbox dcm_checker #(.DW(DW), .BYTE_W(BYTE_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
  .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx),
  .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx), .b_oe(b_oe), .b_size(b_size),
  .a_full_n(a_full_n), .b_full_n(b_full_n), .b_dout(b_dout),
  .mail1_q(mail1_q), .mail2_q(mail2_q)
);

// File: tb/dual_clock_mailbox_test.sv
module dual_clock_mailbox_test;
  localparam int DW = 36;

  logic clk_a = 0, clk_b = 0, rst = 1;
  logic a_en = 0, a_wr = 0, a_mbx = 1, a_oe = 1;
  logic b_en = 0, b_wr = 0, b_mbx = 1, b_oe = 1;
  logic [1:0] b_size = 2'b00;
  logic [DW-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_full_n, b_full_n;
  int total = 0, bad = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  dual_clock_mailbox uut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  task automatic a_write(input logic [DW-1:0] d);
    @(negedge clk_a); a_en = 1; a_wr = 1; a_mbx = 1; a_din = d;
    @(negedge clk_a); a_en = 0; a_wr = 0;
  endtask
  task automatic b_write(input logic [DW-1:0] d);
    @(negedge clk_b); b_en = 1; b_wr = 1; b_mbx = 1; b_din = d;
    @(negedge clk_b); b_en = 0; b_wr = 0;
  endtask
  task automatic a_read();
    @(negedge clk_a); a_en = 1; a_wr = 0; a_mbx = 1;
    @(negedge clk_a); a_en = 0;
  endtask
  task automatic b_read();
    @(negedge clk_b); b_en = 1; b_wr = 0; b_mbx = 1;
    @(negedge clk_b); b_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 a_full_n", {35'd0, a_full_n}, 36'd1);
    chk("R1 b_full_n", {35'd0, b_full_n}, 36'd1);
    chk("R1 b_dout", b_dout, '0);
    chk("R1 a_dout", a_dout, '0);
  endtask

  task automatic t_a_to_b(input logic [1:0] sz, input logic [DW-1:0] d, input logic [DW-1:0] exp);
    b_size = sz;
    a_write(d);
    chk("R2 a_full_n low", {35'd0, a_full_n}, '0);
    wait_b(6);
    chk("R2/R8 b_dout mail1", b_dout, exp);
    chk("R5 flag held before read", {35'd0, a_full_n}, '0);
    b_read();
    wait_a(6);
    chk("R5 a_full_n high", {35'd0, a_full_n}, 36'd1);
    wait_b(2);
    chk("R7 mail1 kept after read", b_dout, exp);
  endtask

  task automatic t_b_to_a(input logic [1:0] sz, input logic [DW-1:0] d, input logic [DW-1:0] exp);
    b_size = sz;
    b_write(d);
    chk("R3 b_full_n low", {35'd0, b_full_n}, '0);
    wait_a(6);
    chk("R3/R8 a_dout mail2", a_dout, exp);
    chk("R6 flag held before read", {35'd0, b_full_n}, '0);
    a_read();
    wait_b(6);
    chk("R6 b_full_n high", {35'd0, b_full_n}, 36'd1);
    wait_a(2);
    chk("R7 mail2 kept after read", a_dout, exp);
  endtask

  task automatic t_ignore_full();
    b_size = 2'b00;
    a_write(36'h1_2345_6789);
    a_write(36'hF_EDCB_A987);
    wait_b(6);
    chk("R4 mail1 write dropped", b_dout, 36'h1_2345_6789);
    b_write(36'h0_5555_AAAA);
    b_write(36'h0_0000_1111);
    wait_a(6);
    chk("R4 mail2 write dropped", a_dout, 36'h0_5555_AAAA);
    b_read(); a_read();
    wait_a(8);
    a_write(36'h3_0303_0303);
    wait_b(6);
    chk("R7 new write accepted", b_dout, 36'h3_0303_0303);
    b_read();
    wait_a(8);
  endtask

  task automatic t_mux();
    @(negedge clk_a); a_mbx = 0; a_fifo_q = 36'hA_BCDE_F012;
    wait_a(2);
    chk("R9 a_dout fifo", a_dout, 36'hA_BCDE_F012);
    @(negedge clk_a); a_oe = 0;
    wait_a(1);
    chk("R9 a_dout disabled", a_dout, '0);
    @(negedge clk_a); a_oe = 1; a_mbx = 1;
    @(negedge clk_b); b_mbx = 0; b_fifo_q = 36'h5_A5A5_A5A5;
    wait_b(1);
    chk("R9 b_dout fifo", b_dout, 36'h5_A5A5_A5A5);
    @(negedge clk_b); b_mbx = 1;
    wait_b(1);
    chk("R9 b_dout mail", b_dout, 36'h3_0303_0303);
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_a(10);
    t_reset();
    @(negedge clk_a); rst = 0;
    wait_b(3);
    t_reset();
    t_a_to_b(2'b00, 36'hF_1234_5678, 36'hF_1234_5678);
    t_b_to_a(2'b00, 36'h8_7654_3210, 36'h8_7654_3210);
    t_a_to_b(2'b01, 36'hF_FFFF_FFFF, 36'h0_0003_FFFF);
    t_b_to_a(2'b01, 36'hF_FFFF_FFFF, 36'h0_0003_FFFF);
    t_a_to_b(2'b10, 36'hF_FFFF_FFFF, 36'h0_0000_01FF);
    t_b_to_a(2'b10, 36'hF_FFFF_FFFF, 36'h0_0000_01FF);
    t_a_to_b(2'b11, 36'hC_0000_0003, 36'hC_0000_0003);
    t_ignore_full();
    t_mux();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule